// File: doc/BRIEF.md
# I/O Translation Cache with Shootdown

This block holds up to sixteen completed address translations for an I/O memory management unit. Each entry maps the virtual page number of a 32-bit I/O virtual address (a 4 KiB page) to a physical page number and two permission bits. A requester presents an address. One cycle later the block answers with a hit and the cached translation, or with a miss that requests a table walk. While the walk is outstanding the block refuses new lookups. The walker ends it with a fill, which either installs the translation or reports that no translation exists.

Two invalidation inputs keep the cache coherent with the tables in memory. The shootdown input removes only the entry whose page matches a given address. The flush input clears everything and is used after a translation fault, before the fault is acknowledged. Directory-level data is never kept apart from page entries, and misses are never cached. A shootdown of the first page of a newly created region therefore leaves nothing stale for that region. Replacement uses a round-robin pointer.

The controller has two states. TC_READY accepts lookups. TC_WALK waits for the walker. Transition T1 (TC_READY to TC_WALK) happens when an accepted lookup misses. Transition T2 (TC_WALK to TC_READY) happens on any fill strobe. In every other case the state holds.

Top module: `translation_cache`

## Requirements
- R1: The tag is address bits 31:12. A lookup of any address whose bits 31:12 equal a valid entry's page hits, whatever bits 11:0 hold. It returns that entry's physical page and permissions (bit 0 read, bit 1 write).
- R2: An accepted lookup (lk_valid while lk_ready is high) gives rsp_valid exactly one cycle later. The answer reflects the cache contents before any fill, shootdown or flush presented in the same cycle as the lookup.
- R3: On a miss, rsp_hit is 0, rsp_ppn and rsp_perm are 0, and walk_req is high for that single response cycle with walk_vpn equal to the missed page. The state takes T1 and lk_ready drops. Lookups presented while the state is TC_WALK get no response.
- R4: A fill strobe (fill_valid) in TC_WALK takes T2, so lk_ready and walk_pending change in the next cycle. With fill_ok high the fill installs its translation. With fill_ok low it writes nothing.
- R5: A fill of a page not yet cached goes into the slot at the round-robin pointer, which then advances by one and wraps after the last slot. Once all slots are full, the oldest allocation is evicted first.
- R6: A fill of a page that is already cached overwrites that entry in place and does not move the pointer.
- R7: A shootdown removes only the entry whose page equals shoot_va bits 31:12. Every other entry stays valid.
- R8: When a shootdown and a fill of the same page arrive in the same cycle, the shootdown wins and the page ends uncached.
- R9: flush_all invalidates every entry, including one being filled in the same cycle.
- R10: A miss, or a fill with fill_ok low, creates no entry. A repeated lookup of that page misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_ready | output | 1 | High in TC_READY; lookups are accepted only then |
| rsp_valid | output | 1 | Lookup answer strobe, one cycle after acceptance |
| rsp_hit | output | 1 | Answer is a hit |
| rsp_ppn | output | 20 | Physical page number on a hit, zero on a miss |
| rsp_perm | output | 2 | Permissions on a hit (bit 0 read, bit 1 write) |
| walk_req | output | 1 | One-cycle request to start a table walk |
| walk_vpn | output | 20 | Page to walk, held while the walk is pending |
| walk_pending | output | 1 | High in TC_WALK |
| fill_valid | input | 1 | Walk completion strobe |
| fill_ok | input | 1 | Walk produced a translation |
| fill_vpn | input | 20 | Page of the completed walk |
| fill_ppn | input | 20 | Physical page from the walk |
| fill_perm | input | 2 | Permissions from the walk |
| shoot_valid | input | 1 | Single-page invalidate strobe |
| shoot_va | input | 32 | Address whose page is invalidated |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The answer to a lookup, and walk_req with walk_vpn, are due on the first clock edge after the request. lk_ready and walk_pending change on that same edge, so the response to a fill is visible one cycle after the fill. A fill, shootdown or flush changes the contents on its edge, so its effect shows first in the answer to a lookup issued in the following cycle. The bench drives each stimulus on a falling edge and predicts the result from its own model of the cache contents as they stood before that stimulus. It compares against the outputs on the next falling edge, one rising edge later.

// File: rtl/tc_pkg.sv
package tc_pkg;
    parameter int VA_W   = 32;
    parameter int OFS_W  = 12;
    parameter int VPN_W  = VA_W - OFS_W;
    parameter int PPN_W  = 20;
    parameter int PERM_W = 2;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [PERM_W-1:0] perm_t;

    typedef struct packed {
        logic  valid;
        vpn_t  vpn;
        ppn_t  ppn;
        perm_t perm;
    } tc_entry_t;

    typedef enum logic [0:0] {
        TC_READY = 1'b0,
        TC_WALK  = 1'b1
    } tc_state_e;
endpackage

// File: rtl/tc_victim_ptr.sv
module tc_victim_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Round-robin slot selector; moves only when a new page is allocated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tc_tag_array.sv
module tc_tag_array
    import tc_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    // lookup port (combinational)
    input  vpn_t             lk_vpn,
    output logic             lk_hit,
    output ppn_t             lk_ppn,
    output perm_t            lk_perm,
    // fill port
    input  logic             fill_en,
    input  vpn_t             fill_vpn,
    input  ppn_t             fill_ppn,
    input  perm_t            fill_perm,
    input  logic [IDX_W-1:0] victim,
    output logic             fill_alloc,
    // invalidation
    input  logic             shoot_en,
    input  vpn_t             shoot_vpn,
    input  logic             flush
);
    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    vpn_t               tag_a  [ENTRIES];
    ppn_t               ppn_a  [ENTRIES];
    perm_t              perm_a [ENTRIES];
    logic               fill_hit_any;

    assign fill_hit_any = |fill_match;
    assign fill_alloc   = fill_en && !fill_hit_any;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        tc_entry_t q;
        tc_entry_t d;

        assign vld[g]        = q.valid;
        assign tag_a[g]      = q.vpn;
        assign ppn_a[g]      = q.ppn;
        assign perm_a[g]     = q.perm;
        assign lk_match[g]   = q.valid && (q.vpn == lk_vpn);
        assign fill_match[g] = q.valid && (q.vpn == fill_vpn);

        // Update order: fill first, then shootdown, then flush, so both
        // invalidations override a fill presented in the same cycle.
        always_comb begin
            d = q;
            if (fill_en && (fill_match[g] || (!fill_hit_any && victim == SLOT))) begin
                d = '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn, perm: fill_perm};
            end
            if (shoot_en && d.vpn == shoot_vpn) begin
                d.valid = 1'b0;
            end
            if (flush) begin
                d.valid = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end
    end

    // Match vector is at most one-hot, so an OR reduction acts as the mux.
    always_comb begin
        lk_hit  = |lk_match;
        lk_ppn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_ppn  = lk_ppn | ppn_a[i];
                lk_perm = lk_perm | perm_a[i];
            end
        end
    end

    // ---- checks kept beside the storage they guard ----
    logic shoot_pend_q;
    vpn_t shoot_key_q;
    logic shoot_key_live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shoot_pend_q <= 1'b0;
            shoot_key_q  <= '0;
        end else begin
            shoot_pend_q <= shoot_en;
            shoot_key_q  <= shoot_vpn;
        end
    end

    always_comb begin
        shoot_key_live = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && tag_a[i] == shoot_key_q) begin
                shoot_key_live = 1'b1;
            end
        end
    end

    assert_shoot_removes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shoot_pend_q |-> !shoot_key_live);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));

    assert_tag_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fill_match));
endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
    import tc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lk_valid,
    input  vpn_t  lk_vpn,
    input  logic  lk_hit_c,
    input  ppn_t  lk_ppn_c,
    input  perm_t lk_perm_c,
    input  logic  fill_valid,
    output logic  lk_ready,
    output logic  walk_pending,
    output logic  rsp_valid,
    output logic  rsp_hit,
    output ppn_t  rsp_ppn,
    output perm_t rsp_perm,
    output logic  walk_req,
    output vpn_t  walk_vpn
);
    tc_state_e state_q;
    tc_state_e state_d;
    logic      accept;

    assign lk_ready     = (state_q == TC_READY);
    assign walk_pending = (state_q == TC_WALK);
    assign accept       = lk_valid && lk_ready;
    assign walk_req     = rsp_valid && !rsp_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TC_READY: if (accept && !lk_hit_c) state_d = TC_WALK;   // T1
            TC_WALK:  if (fill_valid)          state_d = TC_READY;  // T2
            default:  state_d = TC_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TC_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered answer: one cycle after an accepted lookup.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_perm  <= '0;
            walk_vpn  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && lk_hit_c;
            rsp_ppn   <= (accept && lk_hit_c) ? lk_ppn_c : '0;
            rsp_perm  <= (accept && lk_hit_c) ? lk_perm_c : '0;
            if (accept && !lk_hit_c) begin
                walk_vpn <= lk_vpn;
            end
        end
    end

    assert_answer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid);

    assert_no_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rsp_valid);

    assert_miss_walks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (walk_pending && !lk_ready));

    assert_fill_ends_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_pending && fill_valid) |=> lk_ready);
endmodule

// File: rtl/translation_cache.sv
module translation_cache
    import tc_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic              walk_pending,
    input  logic              fill_valid,
    input  logic              fill_ok,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              shoot_valid,
    input  logic [VA_W-1:0]   shoot_va,
    input  logic              flush_all
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    vpn_t             lk_vpn;
    vpn_t             shoot_vpn;
    logic             hit_c;
    ppn_t             ppn_c;
    perm_t            perm_c;
    logic             fill_en;
    logic             alloc;
    logic [IDX_W-1:0] victim;
    logic             unused_ofs;

    assign lk_vpn     = lk_va[VA_W-1:OFS_W];
    assign shoot_vpn  = shoot_va[VA_W-1:OFS_W];
    assign fill_en    = fill_valid && fill_ok;
    assign unused_ofs = ^{lk_va[OFS_W-1:0], shoot_va[OFS_W-1:0]};

    tc_tag_array #(.ENTRIES(ENTRIES)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (lk_vpn),
        .lk_hit     (hit_c),
        .lk_ppn     (ppn_c),
        .lk_perm    (perm_c),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .fill_perm  (fill_perm),
        .victim     (victim),
        .fill_alloc (alloc),
        .shoot_en   (shoot_valid),
        .shoot_vpn  (shoot_vpn),
        .flush      (flush_all)
    );

    tc_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (alloc),
        .ptr     (victim)
    );

    tc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid     (lk_valid),
        .lk_vpn       (lk_vpn),
        .lk_hit_c     (hit_c),
        .lk_ppn_c     (ppn_c),
        .lk_perm_c    (perm_c),
        .fill_valid   (fill_valid),
        .lk_ready     (lk_ready),
        .walk_pending (walk_pending),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_ppn      (rsp_ppn),
        .rsp_perm     (rsp_perm),
        .walk_req     (walk_req),
        .walk_vpn     (walk_vpn)
    );
endmodule

// File: tb/sim_translation_cache.sv
`timescale 1ns/1ps
module sim_translation_cache;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_va;
    logic        lk_ready;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [19:0] rsp_ppn;
    logic [1:0]  rsp_perm;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_pending;
    logic        fill_valid;
    logic        fill_ok;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [1:0]  fill_perm;
    logic        shoot_valid;
    logic [31:0] shoot_va;
    logic        flush_all;

    always #2 clk = ~clk;

    translation_cache #(.ENTRIES(N)) u0 (.*);

    // reference model
    bit          mv    [N];
    logic [19:0] mtag  [N];
    logic [19:0] mppn  [N];
    logic [1:0]  mperm [N];
    int          mptr;
    bit          mwalk;
    int          total = 0;
    int          bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mfind(input logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == vpn) return i;
        return -1;
    endfunction

    // Drive one cycle of stimulus at a falling edge, predict, check one edge later.
    task automatic step(input bit lv, input logic [31:0] lva,
                        input bit fv, input bit fok, input logic [19:0] fvpn,
                        input logic [19:0] fppn, input logic [1:0] fperm,
                        input bit sv, input logic [31:0] sva, input bit fl,
                        input string htag);
        bit          e_rv, e_hit;
        logic [19:0] e_ppn;
        logic [1:0]  e_perm;
        int          idx;
        lk_valid = lv; lk_va = lva;
        fill_valid = fv; fill_ok = fok; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm;
        shoot_valid = sv; shoot_va = sva; flush_all = fl;
        e_rv = lv && !mwalk;
        idx = mfind(lva[31:12]);
        e_hit  = e_rv && (idx >= 0);
        e_ppn  = e_hit ? mppn[idx] : 20'h0;
        e_perm = e_hit ? mperm[idx] : 2'b0;
        if (fv && fok) begin
            idx = mfind(fvpn);
            if (idx < 0) begin
                idx = mptr;
                mptr = (mptr + 1) % N;
            end
            mv[idx] = 1; mtag[idx] = fvpn; mppn[idx] = fppn; mperm[idx] = fperm;
        end
        if (sv) for (int i = 0; i < N; i++) if (mtag[i] == sva[31:12]) mv[i] = 0;
        if (fl) for (int i = 0; i < N; i++) mv[i] = 0;
        if (!mwalk) begin
            if (e_rv && !e_hit) mwalk = 1;
        end else if (fv) begin
            mwalk = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == e_rv, "R2", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
        if (e_rv) begin
            chk(rsp_hit == e_hit, htag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
            chk(rsp_ppn == e_ppn, e_hit ? htag : "R3", "rsp_ppn", 32'(rsp_ppn), 32'(e_ppn));
            chk(rsp_perm == e_perm, e_hit ? htag : "R3", "rsp_perm", 32'(rsp_perm), 32'(e_perm));
            chk(walk_req == !e_hit, "R3", "walk_req", 32'(walk_req), 32'(!e_hit));
            if (!e_hit) chk(walk_vpn == lva[31:12], "R3", "walk_vpn", 32'(walk_vpn), 32'(lva[31:12]));
        end else begin
            chk(walk_req == 1'b0, "R3", "walk_req idle", 32'(walk_req), 32'h0);
        end
        chk(lk_ready == !mwalk, "R4", "lk_ready", 32'(lk_ready), 32'(!mwalk));
        chk(walk_pending == mwalk, "R4", "walk_pending", 32'(walk_pending), 32'(mwalk));
    endtask

    task automatic look(input logic [31:0] va, input string htag);
        step(1, va, 0, 0, 20'h0, 20'h0, 2'b0, 0, 32'h0, 0, htag);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] perm);
        step(0, 32'h0, 1, 1, vpn, ppn, perm, 0, 32'h0, 0, "R4");
    endtask

    task automatic end_walk();
        step(0, 32'h0, 1, 0, 20'h0, 20'h0, 2'b0, 0, 32'h0, 0, "R4");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7331);
        rst_n = 0; lk_valid = 0; lk_va = 0; fill_valid = 0; fill_ok = 0; fill_vpn = 0;
        fill_ppn = 0; fill_perm = 0; shoot_valid = 0; shoot_va = 0; flush_all = 0;
        for (int i = 0; i < N; i++) begin mv[i] = 0; mtag[i] = 0; mppn[i] = 0; mperm[i] = 0; end
        mptr = 0; mwalk = 0;
        repeat (3) @(negedge clk);
        chk(lk_ready == 1'b1, "R4", "reset lk_ready", 32'(lk_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R2", "reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk(walk_req == 1'b0, "R3", "reset walk_req", 32'(walk_req), 32'h0);
        chk(walk_pending == 1'b0, "R4", "reset walk_pending", 32'(walk_pending), 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R3: miss, then an ignored lookup while the walk is open, ended by a fill
        look(32'h1234_5678, "R3");
        step(1, 32'h1234_5000, 1, 1, 20'h12345, 20'hABCDE, 2'b11, 0, 32'h0, 0, "R3");
        // R1: any offset within the page hits
        look(32'h1234_5FFF, "R1");
        look(32'h1234_5000, "R1");
        // R10: faulted walk leaves no entry
        look(32'h2222_2000, "R10");
        end_walk();
        look(32'h2222_2ABC, "R10");
        end_walk();
        // R9: flush clears the cached page
        step(0, 32'h0, 0, 0, 20'h0, 20'h0, 2'b0, 0, 32'h0, 1, "R9");
        look(32'h1234_5000, "R9");
        end_walk();
        // R5: seventeen allocations evict the oldest
        for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h50000 + 20'(i), 2'(i));
        fill(20'h00200, 20'h60000, 2'b01);
        look(32'h0010_0000, "R5");
        end_walk();
        look(32'h0010_1000, "R5");
        // R6: overwrite in place, pointer stays
        fill(20'h00101, 20'h7777A, 2'b10);
        look(32'h0010_1004, "R6");
        fill(20'h00300, 20'h61111, 2'b11);
        look(32'h0010_1000, "R6");
        end_walk();
        look(32'h0010_2000, "R6");
        // R7: shootdown removes only the matching page
        step(0, 32'h0, 0, 0, 20'h0, 20'h0, 2'b0, 1, 32'h0010_2123, 0, "R7");
        look(32'h0010_2000, "R7");
        end_walk();
        look(32'h0010_3000, "R7");
        // R8: shootdown beats a same-cycle fill of the same page
        step(0, 32'h0, 1, 1, 20'h00400, 20'h12121, 2'b11, 1, 32'h0040_0000, 0, "R8");
        look(32'h0040_0000, "R8");
        end_walk();
        // R9: flush beats a same-cycle fill
        step(0, 32'h0, 1, 1, 20'h00500, 20'h13131, 2'b01, 0, 32'h0, 1, "R9");
        look(32'h0050_0000, "R9");
        end_walk();
        look(32'h0010_3000, "R9");
        end_walk();
        // R2: lookup sees contents before a same-cycle fill
        step(1, 32'h0060_0000, 1, 1, 20'h00600, 20'h14141, 2'b10, 0, 32'h0, 0, "R2");
        end_walk();
        look(32'h0060_0010, "R2");

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            bit          lv, fv, fok, sv, fl;
            logic [19:0] lvpn, fvpn;
            lv   = ($urandom % 10) < 7;
            lvpn = 20'h00A00 + 20'($urandom % 24);
            fok  = ($urandom % 10) != 0;
            if (mwalk && ($urandom % 2 == 0)) begin
                fv = 1; fvpn = walk_vpn;
            end else begin
                fv = ($urandom % 100) < 15; fvpn = 20'h00A00 + 20'($urandom % 24);
            end
            sv = ($urandom % 100) < 8;
            fl = ($urandom % 100) < 2;
            step(lv, {lvpn, 12'($urandom)}, fv, fok, fvpn, 20'($urandom), 2'($urandom),
                 sv, {20'h00A00 + 20'($urandom % 24), 12'($urandom)}, fl, "R1");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule